// File: doc/BRIEF.md
# DC Breaker Switching Sequence Controller

This block sequences the switch commands of a mechanical DC circuit breaker that forces a current zero by discharging a precharged resonant circuit into the main interrupter. A single command level asks for the breaker to be closed (1) or open (0). The block turns changes of that level into timed close and open operations. It drives the main interrupter, the residual current switch and one of several injection switches, and it times every mechanical delay in pulses of a 1 ms strobe.

Two injection branches are used in turn, so the breaker can open a second time in quick succession. Once an opening starts, a programmable dead time discards all further commands. After a set number of openings the breaker locks out until reset. The residual switch opens only once the current-zero indication is seen. If the injection window closes without one, the residual switch stays closed, a fault flag is raised and the breaker locks.

Top module: `brk_seq_ctrl`

## Requirements
- R1: A command change applied before rising clock edge k starts its operation at edge k+2. On a close operation, the main interrupter and residual switch commands go high at the edge that takes the 50th tick after the start, and the injection commands stay low.
- R2: On an open operation, the main interrupter command goes low and the selected injection command goes high at the edge that takes the 8th tick after the start. The residual switch command stays high until a current zero is seen.
- R3: The injection command goes low at the edge that takes the 30th tick after it went high. The operation count (`op_count`) rises by one at that same edge.
- R4: A fall of the command while a close is in progress is discarded. The breaker completes the close and remains closed until a later fall of the command.
- R5: The first opening after reset uses branch A (`inj_cls[0]`), the next uses branch B (`inj_cls[1]`), and no two injection commands are high together.
- R6: The residual switch command goes low on the edge after `izero` is sampled high during the injection phase. At any other time, `izero` has no effect.
- R7: When the count of openings reaches 2, `lockout` is set and all switch commands are low. Command changes are then ignored until `rst`.
- R8: For an opening started at edge e with effective dead time D, a command change whose start edge is e+D or earlier is discarded. One whose start edge is e+D+1 is accepted.
- R9: `dead_ms` = 0 selects a dead time of 250 ms, and values from 1 to 99 are raised to 100 ms. Larger values are used as given.
- R10: A command level that changed during the dead time and is still held when the dead time ends does not start an operation.
- R11: During `rst`, `cfg_init_closed` = 0 gives an open breaker with all commands low, and 1 gives main and residual commands high with `st_closed` set. In both cases the count, `lockout` and `izero_fault` are cleared.
- R12: If no current zero arrives before the injection window ends, the residual command stays high. In that case `izero_fault` and `lockout` are set at the edge where the injection command drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init_closed | input | 1 | State taken during reset: 1 closed, 0 open |
| dead_ms | input | DEAD_W | Dead time in ms; 0 selects the default |
| tick_ms | input | 1 | One-cycle strobe once per millisecond |
| cmd_close | input | 1 | Command level: 1 closed, 0 open |
| izero | input | 1 | Current-zero indication |
| main_cls | output | 1 | Main interrupter closed command |
| resid_cls | output | 1 | Residual switch closed command |
| inj_cls | output | N_BRANCH | Injection switch closed commands, one per branch |
| st_closed | output | 1 | Breaker is in the closed state |
| lockout | output | 1 | Breaker is locked open |
| izero_fault | output | 1 | Injection window ended without a current zero |
| op_count | output | OW | Number of completed openings |

## Verification
The command passes through two synchroniser stages and an edge register. A command change made before edge k is therefore acted on at edge k+2, and a result due N ticks later appears at edge k+2+N. With the tick held high, that means 2+N cycles after the change. The bench counts rising edges and samples on the falling edge, so each delay is checked both at its expected edge and one edge earlier. The dead time is swept over three settings, each with the next command placed on the last discarded edge and on the first accepted one. The residual switch result is due one edge after `izero`, and the bench checks it there.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;

   typedef enum logic [2:0] {
      ST_OPEN     = 3'd0,
      ST_CLOSING  = 3'd1,
      ST_CLOSED   = 3'd2,
      ST_OPENING  = 3'd3,
      ST_INJECT   = 3'd4,
      ST_LOCK     = 3'd5
   } brk_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/brk_cmd_sync.sv
module brk_cmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic rst_val,
   input  logic din,
   output logic rise,
   output logic fall
);
   if (STAGES < 1) begin : g_bad_stages
      $error("brk_cmd_sync: STAGES must be at least 1");
   end

   logic [STAGES:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe <= {(STAGES + 1){rst_val}};
      else     pipe <= {pipe[STAGES-1:0], din};
   end

   assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
   assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/brk_ms_timer.sv
module brk_ms_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);
   if (W < 1) begin : g_bad_w
      $error("brk_ms_timer: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)               cnt <= '0;
      else if (tick && cnt != '1)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/brk_dead_gate.sv
module brk_dead_gate #(
   parameter int DW  = 10,
   parameter int DEF = 250,
   parameter int MIN = 100
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          arm,
   input  logic [DW-1:0] dead_ms,
   output logic          busy
);
   if (DEF >= (1 << DW) || MIN > DEF || MIN < 1) begin : g_bad_dead
      $error("brk_dead_gate: need 1 <= MIN <= DEF < 2**DW");
   end

   logic [DW-1:0] eff_d, eff_q, cnt;

   assign eff_d = (dead_ms == '0)        ? DW'(DEF) :
                  (dead_ms < DW'(MIN))   ? DW'(MIN) : dead_ms;

   brk_ms_timer #(.W(DW)) u_dead_tmr (
      .clk  (clk),
      .rst  (rst),
      .clr  (arm),
      .tick (tick),
      .cnt  (cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         eff_q <= DW'(DEF);
      end else if (arm) begin
         busy  <= 1'b1;
         eff_q <= eff_d;
      end else if (busy && tick && cnt == eff_q - DW'(1)) begin
         busy  <= 1'b0;
      end
   end
endmodule

// File: rtl/brk_op_count.sv
module brk_op_count #(
   parameter int MAXOPS = 2,
   parameter int NBR    = 2,
   parameter int OW     = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           done,
   output logic [OW-1:0]  ops,
   output logic [NBR-1:0] br_sel,
   output logic           last
);
   localparam int BW = (NBR > 1) ? $clog2(NBR) : 1;

   if (MAXOPS < 1 || MAXOPS >= (1 << OW)) begin : g_bad_ops
      $error("brk_op_count: MAXOPS must fit in OW bits and be at least 1");
   end
   if (NBR < 1) begin : g_bad_nbr
      $error("brk_op_count: NBR must be at least 1");
   end

   logic [BW-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         ops <= '0;
         idx <= '0;
      end else if (done) begin
         if (ops != OW'(MAXOPS)) ops <= ops + 1'b1;
         idx <= (idx == BW'(NBR - 1)) ? '0 : idx + 1'b1;
      end
   end

   for (genvar i = 0; i < NBR; i++) begin : g_sel
      assign br_sel[i] = (idx == BW'(i));
   end

   assign last = (ops >= OW'(MAXOPS - 1));
endmodule

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl
   import brk_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int T_OPEN_MS   = 8,
   parameter int T_CLOSE_MS  = 50,
   parameter int T_INJ_MS    = 30,
   parameter int DEAD_W      = 10,
   parameter int DEAD_DEF_MS = 250,
   parameter int DEAD_MIN_MS = 100,
   parameter int MAX_OPS     = 2,
   parameter int N_BRANCH    = 2,
   localparam int OW         = $clog2(MAX_OPS + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_init_closed,
   input  logic [DEAD_W-1:0]   dead_ms,
   input  logic                tick_ms,
   input  logic                cmd_close,
   input  logic                izero,
   output logic                main_cls,
   output logic                resid_cls,
   output logic [N_BRANCH-1:0] inj_cls,
   output logic                st_closed,
   output logic                lockout,
   output logic                izero_fault,
   output logic [OW-1:0]       op_count
);
   localparam int TMAX = int'(max3(T_OPEN_MS, T_CLOSE_MS, T_INJ_MS));
   localparam int TW   = $clog2(TMAX + 1);

   if (T_OPEN_MS < 1 || T_CLOSE_MS < 1 || T_INJ_MS < 1) begin : g_bad_delay
      $error("brk_seq_ctrl: every mechanical delay must be at least 1 ms");
   end
   if (DEAD_MIN_MS <= T_OPEN_MS + T_INJ_MS) begin : g_bad_dead_min
      $error("brk_seq_ctrl: minimum dead time must exceed the opening sequence");
   end

   brk_state_e          state_q, state_d;
   logic                resid_q, resid_d, fault_q, fault_d;
   logic                rise, fall, dead_busy, arm, op_done, last;
   logic [TW-1:0]       cnt;
   logic [N_BRANCH-1:0] br_sel;
   logic                hit_open, hit_close, hit_inj;

   brk_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .rst_val (cfg_init_closed),
      .din     (cmd_close),
      .rise    (rise),
      .fall    (fall)
   );

   brk_ms_timer #(.W(TW)) u_seq_tmr (
      .clk  (clk),
      .rst  (rst),
      .clr  (state_d != state_q),
      .tick (tick_ms),
      .cnt  (cnt)
   );

   brk_dead_gate #(.DW(DEAD_W), .DEF(DEAD_DEF_MS), .MIN(DEAD_MIN_MS)) u_dead (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_ms),
      .arm     (arm),
      .dead_ms (dead_ms),
      .busy    (dead_busy)
   );

   brk_op_count #(.MAXOPS(MAX_OPS), .NBR(N_BRANCH), .OW(OW)) u_ops (
      .clk    (clk),
      .rst    (rst),
      .done   (op_done),
      .ops    (op_count),
      .br_sel (br_sel),
      .last   (last)
   );

   assign hit_open  = tick_ms && (cnt == TW'(T_OPEN_MS - 1));
   assign hit_close = tick_ms && (cnt == TW'(T_CLOSE_MS - 1));
   assign hit_inj   = tick_ms && (cnt == TW'(T_INJ_MS - 1));

   always_comb begin
      state_d = state_q;
      resid_d = resid_q;
      fault_d = fault_q;
      arm     = 1'b0;
      op_done = 1'b0;
      unique case (state_q)
         ST_OPEN: begin
            if (rise && !dead_busy) state_d = ST_CLOSING;
         end
         ST_CLOSING: begin
            if (hit_close) begin
               state_d = ST_CLOSED;
               resid_d = 1'b1;
            end
         end
         ST_CLOSED: begin
            if (fall && !dead_busy) begin
               state_d = ST_OPENING;
               arm     = 1'b1;
            end
         end
         ST_OPENING: begin
            if (hit_open) state_d = ST_INJECT;
         end
         ST_INJECT: begin
            if (izero) resid_d = 1'b0;
            if (hit_inj) begin
               op_done = 1'b1;
               if (resid_q && !izero) begin
                  fault_d = 1'b1;
                  state_d = ST_LOCK;
               end else begin
                  state_d = last ? ST_LOCK : ST_OPEN;
               end
            end
         end
         ST_LOCK: state_d = ST_LOCK;
         default: state_d = ST_LOCK;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= cfg_init_closed ? ST_CLOSED : ST_OPEN;
         resid_q <= cfg_init_closed;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         resid_q <= resid_d;
         fault_q <= fault_d;
      end
   end

   assign main_cls    = (state_q == ST_CLOSED) || (state_q == ST_OPENING);
   assign resid_cls   = resid_q;
   assign inj_cls     = (state_q == ST_INJECT) ? br_sel : '0;
   assign st_closed   = (state_q == ST_CLOSED);
   assign lockout     = (state_q == ST_LOCK);
   assign izero_fault = fault_q;

   AST_INJ_MAIN_OPEN: assert property (@(posedge clk) disable iff (rst)
      (|inj_cls) |-> !main_cls); // R2
   AST_INJ_ONE_BRANCH: assert property (@(posedge clk) disable iff (rst)
      $onehot0(inj_cls)); // R5
   AST_RESID_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
      $fell(resid_cls) |-> $past(izero)); // R6
   AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (rst)
      lockout |=> lockout); // R7
   AST_COUNT_ON_INJ_END: assert property (@(posedge clk) disable iff (rst)
      (op_count != $past(op_count)) |-> $past(|inj_cls)); // R3
   AST_CLOSE_OUTSIDE_DEAD: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CLOSING && $past(state_q) == ST_OPEN) |-> !$past(dead_busy)); // R8
   AST_FAULT_KEEPS_RESID: assert property (@(posedge clk) disable iff (rst)
      $rose(izero_fault) |-> resid_cls); // R12
endmodule

// File: tb/brk_seq_ctrl_bench.sv
`timescale 1ns/1ps
module brk_seq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_init_closed = 1'b0;
   logic [9:0] dead_ms = '0;
   logic       tick_ms = 1'b1;
   logic       cmd_close = 1'b0;
   logic       izero = 1'b0;
   logic       main_cls, resid_cls, st_closed, lockout, izero_fault;
   logic [1:0] inj_cls;
   logic [1:0] op_count;
   logic [6:0] o;
   int         cyc = 0;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   brk_seq_ctrl u_brk_seq_ctrl (
      .clk(clk), .rst(rst), .cfg_init_closed(cfg_init_closed), .dead_ms(dead_ms),
      .tick_ms(tick_ms), .cmd_close(cmd_close), .izero(izero),
      .main_cls(main_cls), .resid_cls(resid_cls), .inj_cls(inj_cls),
      .st_closed(st_closed), .lockout(lockout), .izero_fault(izero_fault),
      .op_count(op_count)
   );

   // {main, resid, injB, injA, closed, lockout, fault}
   assign o = {main_cls, resid_cls, inj_cls[1], inj_cls[0], st_closed, lockout, izero_fault};

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic at_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic do_reset(input logic init, input logic [9:0] d);
      @(negedge clk);
      rst = 1'b1; cfg_init_closed = init; cmd_close = init; dead_ms = d; izero = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      at_cyc(cyc + 4);
   endtask

   task automatic pulse_zero(input int c);
      at_cyc(c); izero = 1'b1;
      at_cyc(c + 1); izero = 1'b0;
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c, c1, c2;
      int dset[3] = '{0, 50, 130};
      int deff[3] = '{250, 100, 130};

      // R11: open initial state
      do_reset(1'b0, 10'd0);
      chk("R11 init open", o, 7'b0000000);
      chk("R11 count cleared", op_count, 0);

      // R1 close, R4 fall during closing discarded
      c = cyc; cmd_close = 1'b1;
      at_cyc(c + 10); cmd_close = 1'b0;
      at_cyc(c + 52); chk("R1 close not yet done", o, 7'b0000000);
      at_cyc(c + 53); chk("R1 closed at 50 ticks", o, 7'b1100100);
      at_cyc(c + 150); chk("R4 stays closed", o, 7'b1100100);
      // R6 izero while closed is ignored
      pulse_zero(c + 160);
      at_cyc(c + 163); chk("R6 izero ignored when closed", o, 7'b1100100);
      at_cyc(c + 170); cmd_close = 1'b1;

      // first opening: R2, R5, R6, R3
      at_cyc(c + 180); c1 = cyc; cmd_close = 1'b0;
      at_cyc(c1 + 10); chk("R2 main still closed", o, 7'b1100000);
      at_cyc(c1 + 11); chk("R2 R5 injection A at 8 ticks", o, 7'b0101000);
      at_cyc(c1 + 20); chk("R6 resid held before zero", o, 7'b0101000);
      pulse_zero(c1 + 20);
      chk("R6 resid opens after zero", o, 7'b0001000);
      at_cyc(c1 + 40); chk("R3 injection held", o, 7'b0001000);
      at_cyc(c1 + 41); chk("R3 injection released", o, 7'b0000000);
      chk("R3 count one", op_count, 1);

      // R8 R10: rise inside default dead time, level held past its end
      at_cyc(c1 + 50); cmd_close = 1'b1;
      at_cyc(c1 + 300); chk("R10 held level no start", o, 7'b0000000);
      at_cyc(c1 + 310); cmd_close = 1'b0;
      at_cyc(c1 + 315); cmd_close = 1'b1;
      at_cyc(c1 + 367); chk("R1 reclose pending", o, 7'b0000000);
      at_cyc(c1 + 368); chk("R1 reclosed", o, 7'b1100100);

      // second opening: R5 branch B, R7 lockout
      at_cyc(c1 + 380); c2 = cyc; cmd_close = 1'b0;
      at_cyc(c2 + 11); chk("R5 injection B second", o, 7'b0110000);
      pulse_zero(c2 + 20);
      at_cyc(c2 + 41); chk("R7 locked after two", o, 7'b0000010);
      chk("R7 count two", op_count, 2);
      at_cyc(c2 + 300); cmd_close = 1'b1;
      at_cyc(c2 + 400); chk("R7 close ignored", o, 7'b0000010);
      at_cyc(c2 + 410); cmd_close = 1'b0;
      at_cyc(c2 + 500); chk("R7 still locked", o, 7'b0000010);

      // R11: reset clears lockout, closed initial state
      do_reset(1'b1, 10'd50);
      chk("R11 init closed", o, 7'b1100100);
      chk("R11 count cleared again", op_count, 0);

      // R12: no current zero
      do_reset(1'b1, 10'd0);
      c = cyc; cmd_close = 1'b0;
      at_cyc(c + 40); chk("R12 R5 branch A after reset", o, 7'b0101000);
      at_cyc(c + 41); chk("R12 fault and lock", o, 7'b0100011);

      // R8 R9: dead-time boundary sweep
      for (int k = 0; k < 3; k++) begin
         for (int off = 0; off < 2; off++) begin
            do_reset(1'b1, dset[k][9:0]);
            c = cyc; cmd_close = 1'b0;
            pulse_zero(c + 20);
            at_cyc(c + 41); chk("R3 sweep opening counted", op_count, 1);
            at_cyc(c + deff[k] + off); cmd_close = 1'b1;
            at_cyc(c + deff[k] + off + 52); chk("R8 before close edge", st_closed, 0);
            at_cyc(c + deff[k] + off + 53); chk("R8 R9 dead boundary", st_closed, off);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule